// File: doc/BRIEF.md
# Two-Device TDM Cascade Merger

This block is the serial-output stage of one converter in a two-device daisy chain. A frame is 256 bit clocks long and is split into eight 32-bit slots. The block sends its own four 24-bit samples, most significant bit first, in the first four slots. During those same 128 bit clocks it captures whatever arrives on its cascade input, and it sends that data unchanged in slots five to eight. Two instances chained output to input therefore produce one eight-channel frame. The downstream device's own channels come first, followed by the upstream device's channels.

Everything runs on the bit clock. The frame clock is sampled on the rising edge, and its rising edge marks bit 0 of a frame. The cascade input is also sampled on the rising edge. The serial output is updated on the falling edge, so a neighbour sampling on the rising edge sees stable data. The local samples are taken in once per frame, on the last bit clock of the frame before, so they may change at any time during the frame that is being sent. The output stays low until the first frame-clock rising edge has been seen.

Top module: `tdm_cascade_merger`

## Requirements
- R1: After reset, and until the first frame-clock rising edge has been seen, the serial output is 0.
- R2: Local channel k sits in local_samples[k*24 +: 24] and is sent in slot k+1 (bit clocks 32k to 32k+31 of the frame), most significant bit first, from bit 0 of the slot onward. Bit 0 of a frame is the bit clock whose rising edge first samples the frame clock high.
- R3: Bits 24 to 31 of each local slot are 0.
- R4: The 128 cascade-input bits sampled in bit clocks 0 to 127 of a frame are sent, in the order they arrived, in bit clocks 128 to 255 of that same frame.
- R5: The cascade input sampled in bit clocks 128 to 255 has no effect on the output.
- R6: A device whose cascade input is held at 0 sends 0 in all of slots 5 to 8.
- R7: The local samples sent in a frame are the values present on the last bit clock of the previous frame. Changes to local_samples during the frame do not affect that frame.
- R8: The serial output changes only after a falling bit-clock edge. Its value is the same just before and just after each rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Bit clock (256 per frame) |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_clk | input | 1 | Frame clock; rising edge marks bit 0 |
| tdm_in | input | 1 | Cascade input from the upstream device |
| local_samples | input | 96 | Four 24-bit local samples, channel k at bits k*24+23..k*24 |
| tdm_out | output | 1 | Merged serial output, updated on the falling edge |

## Verification
Two instances are chained as in a real system, and a third instance is fed a cascade stream driven directly by the bench. The local samples are swept through all-zero, all-one, the two signed extremes, a walking single bit per channel and an arithmetic series. These patterns show slot swaps, bit-order reversal and padding leaks as distinct word errors. The directly driven instance receives arbitrary 32-bit slot words with the second half of the frame held high. This separates a correct copy of the first half from data leaking in from the second half. One frame changes the local inputs in mid-frame to show that they are captured once per frame.

// File: rtl/tcm_pkg.sv
package tcm_pkg;
  localparam int DEF_SAMPLE_BITS = 24;
  localparam int DEF_SLOT_BITS   = 32;
  localparam int DEF_LOCAL_CH    = 4;

  function automatic int slot_of(int idx, int slot_bits);
    return idx / slot_bits;
  endfunction

  function automatic int bit_in_slot(int idx, int slot_bits);
    return idx % slot_bits;
  endfunction

  // padding bit after the valid sample bits of a slot
  function automatic bit is_pad(int idx, int slot_bits, int sample_bits);
    return bit_in_slot(idx, slot_bits) >= sample_bits;
  endfunction

  // index into packed local samples for frame bit idx (MSB first)
  function automatic int local_sel(int idx, int slot_bits, int sample_bits);
    return slot_of(idx, slot_bits) * sample_bits + sample_bits - 1
           - bit_in_slot(idx, slot_bits);
  endfunction

  // index into the upstream shift buffer for frame bit idx in the 2nd half
  function automatic int upstream_sel(int idx, int frame_bits);
    return frame_bits - 1 - idx;
  endfunction
endpackage

// File: rtl/tcm_frame_timer.sv
module tcm_frame_timer #(
  parameter int FRAME_BITS = 256,
  parameter int IW         = $clog2(FRAME_BITS)
) (
  input  logic          bclk,
  input  logic          rst_n,
  input  logic          frame_clk,
  output logic [IW-1:0] cur_idx,
  output logic [IW-1:0] next_idx,
  output logic          frame_start,
  output logic          locked
);
  logic          fc_q;
  logic [IW-1:0] cnt;

  assign frame_start = frame_clk & ~fc_q;
  assign cur_idx     = frame_start ? '0 : cnt;
  assign next_idx    = cnt;

  always_ff @(posedge bclk) begin
    if (!rst_n) begin
      fc_q   <= 1'b0;
      cnt    <= '0;
      locked <= 1'b0;
    end else begin
      fc_q <= frame_clk;
      cnt  <= cur_idx + 1'b1;
      if (frame_start) locked <= 1'b1;
    end
  end
endmodule

// File: rtl/tcm_upstream_buf.sv
module tcm_upstream_buf #(
  parameter int HALF_BITS = 128,
  parameter int IW        = 8
) (
  input  logic                 bclk,
  input  logic                 rst_n,
  input  logic [IW-1:0]        cur_idx,
  input  logic                 ser_in,
  output logic [HALF_BITS-1:0] held
);
  logic capture;
  assign capture = int'(cur_idx) < HALF_BITS;

  always_ff @(posedge bclk) begin
    if (!rst_n)       held <= '0;
    else if (capture) held <= {held[HALF_BITS-2:0], ser_in};
  end
endmodule

// File: rtl/tcm_sample_hold.sv
module tcm_sample_hold #(
  parameter int LW         = 96,
  parameter int FRAME_BITS = 256,
  parameter int IW         = 8
) (
  input  logic          bclk,
  input  logic          rst_n,
  input  logic [IW-1:0] cur_idx,
  input  logic [LW-1:0] samples_in,
  output logic [LW-1:0] held
);
  logic last_bit;
  assign last_bit = int'(cur_idx) == FRAME_BITS - 1;

  always_ff @(posedge bclk) begin
    if (!rst_n)        held <= '0;
    else if (last_bit) held <= samples_in;
  end
endmodule

// File: rtl/tdm_cascade_merger.sv
module tdm_cascade_merger #(
  parameter int SAMPLE_BITS = tcm_pkg::DEF_SAMPLE_BITS,
  parameter int SLOT_BITS   = tcm_pkg::DEF_SLOT_BITS,
  parameter int LOCAL_CH    = tcm_pkg::DEF_LOCAL_CH
) (
  input  logic                          bclk,
  input  logic                          rst_n,
  input  logic                          frame_clk,
  input  logic                          tdm_in,
  input  logic [LOCAL_CH*SAMPLE_BITS-1:0] local_samples,
  output logic                          tdm_out
);
  localparam int HALF_BITS  = LOCAL_CH * SLOT_BITS;
  localparam int FRAME_BITS = 2 * HALF_BITS;
  localparam int IW         = $clog2(FRAME_BITS);
  localparam int LW         = LOCAL_CH * SAMPLE_BITS;
  localparam int LSW        = $clog2(LW);
  localparam int USW        = $clog2(HALF_BITS);

  logic [IW-1:0]        cur_idx;
  logic [IW-1:0]        next_idx;
  logic                 frame_start;
  logic                 locked;
  logic [HALF_BITS-1:0] up_buf;
  logic [LW-1:0]        local_q;
  logic [LSW-1:0]       lsel;
  logic [USW-1:0]       usel;
  logic                 pick_local;
  logic                 pad_bit;
  logic                 next_bit;

  tcm_frame_timer #(.FRAME_BITS(FRAME_BITS), .IW(IW)) timer_i (
    .bclk(bclk), .rst_n(rst_n), .frame_clk(frame_clk),
    .cur_idx(cur_idx), .next_idx(next_idx),
    .frame_start(frame_start), .locked(locked)
  );

  tcm_upstream_buf #(.HALF_BITS(HALF_BITS), .IW(IW)) upbuf_i (
    .bclk(bclk), .rst_n(rst_n), .cur_idx(cur_idx),
    .ser_in(tdm_in), .held(up_buf)
  );

  tcm_sample_hold #(.LW(LW), .FRAME_BITS(FRAME_BITS), .IW(IW)) hold_i (
    .bclk(bclk), .rst_n(rst_n), .cur_idx(cur_idx),
    .samples_in(local_samples), .held(local_q)
  );

  // bit for the coming rising edge, chosen from the frame position
  always_comb begin
    pick_local = int'(next_idx) < HALF_BITS;
    pad_bit    = tcm_pkg::is_pad(int'(next_idx), SLOT_BITS, SAMPLE_BITS);
    lsel       = LSW'(tcm_pkg::local_sel(int'(next_idx), SLOT_BITS, SAMPLE_BITS));
    usel       = USW'(tcm_pkg::upstream_sel(int'(next_idx), FRAME_BITS));
    if (pick_local) next_bit = pad_bit ? 1'b0 : local_q[lsel];
    else            next_bit = up_buf[usel];
  end

  always_ff @(negedge bclk) begin
    if (!rst_n) tdm_out <= 1'b0;
    else        tdm_out <= locked & next_bit;
  end
endmodule

// File: rtl/tdm_cascade_chk.sv
module tdm_cascade_chk #(
  parameter int IW          = 8,
  parameter int HALF_BITS   = 128,
  parameter int LW          = 96,
  parameter int SLOT_BITS   = 32,
  parameter int SAMPLE_BITS = 24
) (
  input logic                 bclk,
  input logic                 rst_n,
  input logic                 tdm_out,
  input logic                 locked,
  input logic                 frame_start,
  input logic [IW-1:0]        cur_idx,
  input logic [HALF_BITS-1:0] up_buf,
  input logic [LW-1:0]        local_q
);
  a_r1_silent_until_lock: assert property (@(posedge bclk) disable iff (!rst_n)
    !locked |-> !tdm_out);

  a_r3_pad_zero: assert property (@(posedge bclk) disable iff (!rst_n)
    (locked && int'(cur_idx) < HALF_BITS &&
     (int'(cur_idx) % SLOT_BITS) >= SAMPLE_BITS) |-> !tdm_out);

  a_r5_buf_frozen: assert property (@(posedge bclk) disable iff (!rst_n)
    int'(cur_idx) >= HALF_BITS |=> $stable(up_buf));

  a_r7_samples_hold: assert property (@(posedge bclk) disable iff (!rst_n)
    int'(cur_idx) != 2*HALF_BITS - 1 |=> $stable(local_q));

  a_r2_idx_step: assert property (@(posedge bclk) disable iff (!rst_n)
    (locked && !frame_start) |=> cur_idx == IW'($past(cur_idx) + 1'b1));
endmodule

bind tdm_cascade_merger tdm_cascade_chk #(
  .IW(IW), .HALF_BITS(HALF_BITS), .LW(LW),
  .SLOT_BITS(SLOT_BITS), .SAMPLE_BITS(SAMPLE_BITS)
) chk_i (
  .bclk(bclk), .rst_n(rst_n), .tdm_out(tdm_out), .locked(locked),
  .frame_start(frame_start), .cur_idx(cur_idx), .up_buf(up_buf),
  .local_q(local_q)
);

// File: tb/tdm_cascade_merger_tb.sv
module tdm_cascade_merger_tb_top;
  localparam int FB = 256;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_clk = 1'b0;
  logic raw_in = 1'b0;
  logic [95:0] loc_a = '0, loc_b = '0;
  logic a_out, b_out, c_out;

  int total = 0, fails = 0, edge_bad = 0;
  logic bits_a[FB], bits_b[FB], bits_c[FB];
  logic [23:0] cur_a[4], cur_b[4];
  logic [31:0] pat[4];

  always #4 clk = ~clk;

  tdm_cascade_merger up_i (.bclk(clk), .rst_n(rst_n), .frame_clk(frame_clk),
    .tdm_in(1'b0), .local_samples(loc_a), .tdm_out(a_out));
  tdm_cascade_merger dut_i (.bclk(clk), .rst_n(rst_n), .frame_clk(frame_clk),
    .tdm_in(a_out), .local_samples(loc_b), .tdm_out(b_out));
  tdm_cascade_merger raw_i (.bclk(clk), .rst_n(rst_n), .frame_clk(frame_clk),
    .tdm_in(raw_in), .local_samples(96'h0), .tdm_out(c_out));

  function automatic logic [23:0] val(int f, int dev, int ch);
    case (f)
      1: return 24'h000000;
      2: return 24'hFFFFFF;
      3: return 24'h800000;
      4: return 24'h7FFFFF;
      5: return 24'(1) << (ch * 5 + dev);
      default: return 24'(f * 24'h13579B + ch * 24'h2468AD + dev * 24'h0F0F0F);
    endcase
  endfunction

  function automatic logic [95:0] pack(int f, int dev);
    logic [95:0] v = '0;
    for (int k = 0; k < 4; k++) v[k*24 +: 24] = val(f, dev, k);
    return v;
  endfunction

  function automatic logic [31:0] word(logic bits[FB], int slot);
    logic [31:0] w = '0;
    for (int i = 0; i < 32; i++) w[31-i] = bits[slot*32 + i];
    return w;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_frame(input int f, input bit mid);
    logic [2:0] snap;
    for (int k = 0; k < 4; k++)
      pat[k] = (f == 1) ? 32'hFFFFFFFF : 32'(f * 32'h9E3779B9) ^ (k * 32'h01010101);
    for (int idx = 0; idx < FB; idx++) begin
      @(negedge clk); #2;
      frame_clk = (idx < 32);
      raw_in = (idx < 128) ? pat[idx/32][31 - idx%32] : 1'b1;
      if (idx == 0)          begin loc_a = pack(f+1, 0); loc_b = pack(f+1, 1); end
      if (mid && idx == 40)  begin loc_a = ~pack(f+1, 0); loc_b = ~pack(f+1, 1); end
      if (mid && idx == 200) begin loc_a = pack(f+1, 0); loc_b = pack(f+1, 1); end
      bits_a[idx] = a_out; bits_b[idx] = b_out; bits_c[idx] = c_out;
      snap = {a_out, b_out, c_out};
      @(posedge clk); #1;
      if ({a_out, b_out, c_out} !== snap) edge_bad++;
    end
  endtask

  task automatic check_frame(input int f, input bit mid);
    string lt;
    lt = mid ? "R7" : "R2 R3";
    for (int k = 0; k < 4; k++) begin
      check(word(bits_a, k) === {cur_a[k], 8'h00}, {"A local ", lt},
            word(bits_a, k), {cur_a[k], 8'h00});
      check(word(bits_a, k+4) === 32'h0, "R6 A upstream slot",
            word(bits_a, k+4), 32'h0);
      check(word(bits_b, k) === {cur_b[k], 8'h00}, {"B local ", lt},
            word(bits_b, k), {cur_b[k], 8'h00});
      check(word(bits_b, k+4) === {cur_a[k], 8'h00}, "R4 B cascaded slot",
            word(bits_b, k+4), {cur_a[k], 8'h00});
      check(word(bits_c, k+4) === pat[k], "R4 R5 raw cascaded slot",
            word(bits_c, k+4), pat[k]);
    end
  endtask

  initial begin
    #(8 * 150000);
    fails++; total++;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (5) @(posedge clk);
    #1;
    check({a_out, b_out, c_out} === 3'b000, "R1 in reset", {29'h0, a_out, b_out, c_out}, 0);
    @(negedge clk); #2;
    rst_n = 1'b1;
    repeat (6) @(posedge clk);
    #1;
    check({a_out, b_out, c_out} === 3'b000, "R1 before lock", {29'h0, a_out, b_out, c_out}, 0);
    run_frame(0, 1'b0);
    for (int f = 1; f <= 9; f++) begin
      for (int k = 0; k < 4; k++) begin
        cur_a[k] = val(f, 0, k);
        cur_b[k] = val(f, 1, k);
      end
      run_frame(f, f == 5);
      check_frame(f, f == 5);
    end
    check(edge_bad == 0, "R8 output stable across rising edge", 32'(edge_bad), 0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule